// File: doc/BRIEF.md
# Password-Protected Subkey Memory Engine

This block is the byte-level command engine of a secure serial key. It holds three 64-byte subkeys and one 64-byte scratchpad. In each subkey, offsets 00h-07h are an identifier, 08h-0Fh a password, and 10h-3Fh secure data. The scratchpad has no password. A lower layer handles bit timing and device selection. It passes received bytes in, takes bytes to transmit out, and pulses `bus_reset` whenever the bus is reset.

Each transaction opens with three bytes: a function code, an address byte and that byte's complement. The engine then runs one of six functions:

- write or read the scratchpad;
- copy scratchpad blocks into a subkey after a password check;
- re-initialise a subkey's identifier and password;
- write or read subkey data after a password check.

Secure functions first send the identifier and then take the password. A failed read answers with pseudo-random bytes rather than stopping. A successful copy clears the scratchpad blocks it moved.

Both byte streams are valid/ready. A received byte is consumed on a cycle where `rx_valid` and `rx_ready` are both high, and the sender keeps `rx_data` until then. A transmit byte is taken on a cycle where `tx_valid` and `tx_ready` are both high. While `tx_valid` is high and `tx_ready` is low, the engine holds `tx_data` unchanged. The engine never asks for a byte in both directions at once.

Top module: `subkey_engine`

## Requirements
- R1: The address byte holds the area in bits 7:6 (00, 01, 10 = subkeys 0-2, 11 = scratchpad) and the start offset in bits 5:0. The third byte must equal its bitwise complement. The engine goes silent (rx_ready 1, tx_valid 0, every byte discarded, nothing stored) until the next bus reset in any of these cases:
  - the third byte is not the complement;
  - the function code is not one of 96h, 69h, 3Ch, 5Ah, 99h, 66h;
  - a scratchpad function (96h, 69h) names area 00, 01 or 10;
  - a subkey function (3Ch, 5Ah, 99h, 66h) names area 11;
  - 99h starts below offset 10h.
- R2: Function 96h stores each received byte in the scratchpad at the start offset, and the offset rises by one per byte. Bytes arriving after offset 3Fh has been written are discarded.
- R3: Function 69h sends scratchpad bytes from the start offset upward. After offset 3Fh has been sent, it sends FFh.
- R4: Functions 66h, 99h and 5Ah first send the selected subkey's identifier, offsets 00h to 07h in ascending order.
- R5: Function 99h compares the next 8 received bytes with subkey offsets 08h-0Fh.
  - On a match, the following bytes are written from the start offset upward, up to 3Fh, and later bytes are discarded.
  - On any mismatch, nothing is written and all further bytes are discarded.
- R6: Function 66h compares 8 received bytes with the password in the same way.
  - On a match, it sends stored bytes from the start offset.
  - On a mismatch, it sends the low 8 bits of a 16-bit LFSR instead.
  - The LFSR starts at ACE1h after rst_n. It shifts left with new bit 0 = bit15^bit13^bit12^bit10 on every accepted transmit byte of any kind.
  - After offset 3Fh, FFh is sent in both cases.
- R7: Function 5Ah compares 8 received bytes with the identifier. On a mismatch, nothing changes and further bytes are discarded. On a match:
  - all 64 bytes of the subkey become 00h;
  - the next 8 bytes become offsets 00h-07h and the next 8 become 08h-0Fh;
  - later bytes are discarded.
- R8: Function 3Ch first receives an 8-byte selector, first byte least significant, then the 8-byte destination password. The selector must equal one of nine codes:
  - entry 0 (7F5A5D57517F5656h) selects all eight 8-byte blocks;
  - entries 1 to 8 select block 0 to 7 alone (4C696E649DB39A9Ah, 4C69919B624C9A9Ah, 4C966E9B62B3659Ah, 4366616B6D436A6Ah, BC999E9492BC9595h, B36991649D4C9A65h, B3966E649DB36565h, B396919B624C6565h).

  With a matching password and a known selector, the selected blocks are copied to the same offsets of the subkey and cleared to 00h in the scratchpad. Otherwise nothing changes. In both cases, later bytes are discarded.
- R9: A `bus_reset` pulse in any state makes the engine wait for a function code from the next cycle. Stored data is kept.
- R10: After rst_n:
  - all storage reads 00h;
  - the engine waits for a function code with rx_ready 1 and tx_valid 0;
  - rx_ready and tx_valid are never high together;
  - a stalled transmit byte stays stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_reset | input | 1 | One-cycle pulse: bus reset seen by the lower layer |
| rx_valid | input | 1 | Received byte available |
| rx_ready | output | 1 | Engine can take a received byte |
| rx_data | input | 8 | Received byte |
| tx_valid | output | 1 | Engine has a byte to transmit |
| tx_ready | input | 1 | Lower layer takes the transmit byte |
| tx_data | output | 8 | Byte to transmit |

## Verification
All outputs come from registered state. After a handshake or a `bus_reset` edge, `rx_ready`, `tx_valid` and `tx_data` therefore show the next step one cycle later. Storage writes, erasures and copies take effect on the edge that accepts the deciding byte, and show up in the first byte of any later read. The bench drives on falling edges and compares both handshake signals and the transmit byte at the falling edge of every cycle. It does this against a behavioural model of storage and the LFSR, which it advances on each edge where a byte moves. A stalled transmit byte is re-checked on each waiting cycle.

// File: rtl/subkey_pkg.sv
package subkey_pkg;
  localparam logic [7:0] FN_WR_PAD = 8'h96;
  localparam logic [7:0] FN_RD_PAD = 8'h69;
  localparam logic [7:0] FN_COPY   = 8'h3C;
  localparam logic [7:0] FN_SET_PW = 8'h5A;
  localparam logic [7:0] FN_WR_KEY = 8'h99;
  localparam logic [7:0] FN_RD_KEY = 8'h66;
  localparam logic [1:0] AREA_PAD  = 2'b11;

  typedef enum logic [3:0] {
    PH_FN, PH_ADDR, PH_CHK, PH_ID_TX, PH_SEL_RX, PH_PW_RX,
    PH_DAT_RX, PH_NEW_RX, PH_DAT_TX, PH_ONES, PH_DONE
  } phase_e;
endpackage

// File: rtl/subkey_lfsr.sv
module subkey_lfsr #(
  parameter int          W    = 16,
  parameter logic [W-1:0] TAPS = 16'hB400,
  parameter logic [W-1:0] SEED = 16'hACE1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       step,
  output logic [7:0] rnd_byte
);
  logic [W-1:0] state;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    state <= SEED;
    else if (step) state <= {state[W-2:0], ^(state & TAPS)};
  end

  assign rnd_byte = state[7:0];

  // R6: the random source only moves when a byte is handed over
  a_r6_lfsr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(state));
endmodule

// File: rtl/subkey_sel_decode.sv
module subkey_sel_decode #(
  parameter int BLOCKS = 8,
  parameter int BW     = 64,
  parameter logic [BLOCKS:0][BW-1:0] CODES = {
    64'hB396919B624C6565, 64'hB3966E649DB36565, 64'hB36991649D4C9A65,
    64'hBC999E9492BC9595, 64'h4366616B6D436A6A, 64'h4C966E9B62B3659A,
    64'h4C69919B624C9A9A, 64'h4C696E649DB39A9A, 64'h7F5A5D57517F5656 }
) (
  input  logic [BW-1:0]     code,
  output logic              known,
  output logic [BLOCKS-1:0] mask
);
  logic [BLOCKS:0] hit;

  for (genvar g = 0; g <= BLOCKS; g++) begin : g_hit
    assign hit[g] = (code == CODES[g]);
  end

  assign known = |hit;
  assign mask  = hit[0] ? '1 : hit[BLOCKS:1];

  // R8: the code table never selects two entries at once
  always_comb begin
    a_r8_one_hit: assert ($onehot0(hit));
  end
endmodule

// File: rtl/subkey_engine.sv
module subkey_engine
  import subkey_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int KEY_BYTES = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_reset,
  input  logic       rx_valid,
  output logic       rx_ready,
  input  logic [7:0] rx_data,
  output logic       tx_valid,
  input  logic       tx_ready,
  output logic [7:0] tx_data
);
  localparam int DEPTH      = 1 << ADDR_W;
  localparam int CNT_W      = $clog2(KEY_BYTES);
  localparam int SEL_W      = 8 * KEY_BYTES;
  localparam int BLOCKS     = DEPTH / KEY_BYTES;
  localparam int DATA_START = 2 * KEY_BYTES;

  logic [7:0]        mem [4][DEPTH];
  phase_e            phase;
  logic [7:0]        fn;
  logic [1:0]        area;
  logic [ADDR_W-1:0] ptr;
  logic [CNT_W-1:0]  cnt;
  logic              miss_q, pass_q;
  logic [SEL_W-1:0]  sel_q;

  logic              rx_fire, tx_fire, cnt_last, ptr_last, legal, cmp_ok, miss_now;
  logic              sel_known;
  logic [BLOCKS-1:0] blk_mask;
  logic [7:0]        rnd_byte, ref_byte;
  logic [ADDR_W-1:0] ref_idx;

  subkey_lfsr u_rnd (
    .clk(clk), .rst_n(rst_n), .step(tx_fire), .rnd_byte(rnd_byte)
  );

  subkey_sel_decode #(.BLOCKS(BLOCKS), .BW(SEL_W)) u_sel (
    .code(sel_q), .known(sel_known), .mask(blk_mask)
  );

  assign tx_valid = (phase == PH_ID_TX) || (phase == PH_DAT_TX) || (phase == PH_ONES);
  assign rx_ready = !tx_valid;
  assign rx_fire  = rx_valid && rx_ready;
  assign tx_fire  = tx_valid && tx_ready;
  assign cnt_last = (cnt == CNT_W'(KEY_BYTES - 1));
  assign ptr_last = &ptr;
  assign cmp_ok   = (rx_data == ~{area, ptr});

  always_comb begin
    case (phase)
      PH_ID_TX:  tx_data = mem[area][ADDR_W'(cnt)];
      PH_DAT_TX: tx_data = (area == AREA_PAD || pass_q) ? mem[area][ptr] : rnd_byte;
      default:   tx_data = 8'hFF;
    endcase
  end

  always_comb begin
    case (fn)
      FN_WR_PAD, FN_RD_PAD:            legal = (area == AREA_PAD);
      FN_COPY, FN_SET_PW, FN_RD_KEY:   legal = (area != AREA_PAD);
      FN_WR_KEY: legal = (area != AREA_PAD) && (ptr >= ADDR_W'(DATA_START));
      default:                         legal = 1'b0;
    endcase
  end

  // password phase compares against the identifier for 5Ah, else the password
  assign ref_idx  = (fn == FN_SET_PW) ? ADDR_W'(cnt) : ADDR_W'(cnt) + ADDR_W'(KEY_BYTES);
  assign ref_byte = mem[area][ref_idx];
  assign miss_now = ((cnt == '0) ? 1'b0 : miss_q) | (rx_data != ref_byte);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int a = 0; a < 4; a++)
        for (int i = 0; i < DEPTH; i++) mem[a][i] <= '0;
      phase  <= PH_FN;
      fn     <= '0;
      area   <= '0;
      ptr    <= '0;
      cnt    <= '0;
      miss_q <= 1'b0;
      pass_q <= 1'b0;
      sel_q  <= '0;
    end else if (bus_reset) begin
      phase <= PH_FN;
      cnt   <= '0;
    end else begin
      case (phase)
        PH_FN: if (rx_fire) begin
          fn    <= rx_data;
          phase <= PH_ADDR;
        end
        PH_ADDR: if (rx_fire) begin
          {area, ptr} <= rx_data;
          phase       <= PH_CHK;
        end
        PH_CHK: if (rx_fire) begin
          cnt <= '0;
          if (!cmp_ok || !legal) phase <= PH_DONE;
          else begin
            case (fn)
              FN_WR_PAD: phase <= PH_DAT_RX;
              FN_RD_PAD: phase <= PH_DAT_TX;
              FN_COPY:   phase <= PH_SEL_RX;
              default:   phase <= PH_ID_TX;
            endcase
          end
        end
        PH_ID_TX: if (tx_fire) begin
          cnt <= cnt + 1'b1;
          if (cnt_last) phase <= PH_PW_RX;
        end
        PH_SEL_RX: if (rx_fire) begin
          sel_q[{cnt, 3'b000} +: 8] <= rx_data;
          cnt <= cnt + 1'b1;
          if (cnt_last) phase <= PH_PW_RX;
        end
        PH_PW_RX: if (rx_fire) begin
          miss_q <= miss_now;
          cnt    <= cnt + 1'b1;
          if (cnt_last) begin
            case (fn)
              FN_WR_KEY: phase <= miss_now ? PH_DONE : PH_DAT_RX;
              FN_RD_KEY: begin
                pass_q <= !miss_now;
                phase  <= PH_DAT_TX;
              end
              FN_SET_PW: begin
                if (miss_now) phase <= PH_DONE;
                else begin
                  for (int i = 0; i < DEPTH; i++) mem[area][i] <= '0;
                  ptr   <= '0;
                  phase <= PH_NEW_RX;
                end
              end
              default: begin
                if (!miss_now && sel_known) begin
                  for (int b = 0; b < BLOCKS; b++)
                    for (int j = 0; j < KEY_BYTES; j++)
                      if (blk_mask[b]) begin
                        mem[area][b*KEY_BYTES+j]     <= mem[AREA_PAD][b*KEY_BYTES+j];
                        mem[AREA_PAD][b*KEY_BYTES+j] <= '0;
                      end
                end
                phase <= PH_DONE;
              end
            endcase
          end
        end
        PH_DAT_RX: if (rx_fire) begin
          mem[area][ptr] <= rx_data;
          ptr <= ptr + 1'b1;
          if (ptr_last) phase <= PH_DONE;
        end
        PH_NEW_RX: if (rx_fire) begin
          mem[area][ptr] <= rx_data;
          ptr <= ptr + 1'b1;
          if (ptr == ADDR_W'(DATA_START - 1)) phase <= PH_DONE;
        end
        PH_DAT_TX: if (tx_fire) begin
          ptr <= ptr + 1'b1;
          if (ptr_last) phase <= PH_ONES;
        end
        default: ;
      endcase
    end
  end

  // R10: a byte waiting for the lower layer does not change under it
  a_r10_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready && !bus_reset) |=> (tx_valid && $stable(tx_data)));

  // R9: a bus reset always leads to waiting for a received function code
  a_r9_bus_reset: assert property (@(posedge clk) disable iff (!rst_n)
    bus_reset |=> (rx_ready && !tx_valid));

  // R1: the silent state is left only through a bus reset
  a_r1_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_DONE && !bus_reset) |=> (phase == PH_DONE && rx_ready));

  // R3: past the end of an area only all-ones bytes go out
  a_r3_ones_tail: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_ONES && !bus_reset) |=> (tx_valid && tx_data == 8'hFF));
endmodule

// File: tb/subkey_engine_bench.sv
module subkey_engine_bench;
  logic clk = 1'b0, rst_n = 1'b0, bus_reset = 1'b0;
  logic rx_valid = 1'b0, tx_ready = 1'b0;
  logic [7:0] rx_data = 8'h00;
  logic rx_ready, tx_valid;
  logic [7:0] tx_data;

  subkey_engine u_subkey_engine (
    .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data)
  );

  always #2 clk = ~clk;

  int checks = 0, fails = 0;
  bit ended = 1'b0;
  logic [7:0]  m [4][64];
  logic [15:0] lf;
  logic [63:0] codes [9];

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] lstep(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  function automatic logic [63:0] get64(input int a, input int off);
    logic [63:0] v;
    for (int i = 0; i < 8; i++) v[8*i +: 8] = m[a][off+i];
    return v;
  endfunction

  task automatic put(input logic [7:0] b, input string req);
    @(negedge clk);
    check(rx_ready === 1'b1 && tx_valid === 1'b0, req, {rx_ready, tx_valid}, 2'b10);
    rx_valid = 1'b1; rx_data = b;
    @(posedge clk); #1 rx_valid = 1'b0;
  endtask

  task automatic get(input logic [7:0] exp, input string req, input int stall);
    @(negedge clk);
    check(tx_valid === 1'b1 && rx_ready === 1'b0, req, {tx_valid, rx_ready}, 2'b10);
    check(tx_data === exp, req, tx_data, exp);
    for (int k = 0; k < stall; k++) begin
      @(negedge clk);
      check(tx_valid === 1'b1 && tx_data === exp, "R10 stall", tx_data, exp);
    end
    tx_ready = 1'b1;
    @(posedge clk); #1 tx_ready = 1'b0;
    lf = lstep(lf);
  endtask

  task automatic breset();
    @(negedge clk); bus_reset = 1'b1;
    @(posedge clk); #1 bus_reset = 1'b0;
  endtask

  task automatic cmd(input logic [7:0] fn, input logic [1:0] area, input logic [5:0] a, input string req);
    put(fn, req); put({area, a}, req); put(~{area, a}, req);
  endtask

  task automatic rsp(input int a, input int n, input int stall_at);
    cmd(8'h69, 2'b11, 6'(a), "R3");
    for (int i = 0; i < n; i++)
      get((a + i <= 63) ? m[3][a+i] : 8'hFF, "R3", (i == stall_at) ? 3 : 0);
    breset();
  endtask

  task automatic wsp(input int a, input int n, input logic [7:0] seed);
    cmd(8'h96, 2'b11, 6'(a), "R2");
    for (int i = 0; i < n; i++) begin
      put(8'(seed + i * 13), "R2");
      if (a + i <= 63) m[3][a+i] = 8'(seed + i * 13);
    end
    breset();
  endtask

  task automatic send_id(input int k);
    for (int i = 0; i < 8; i++) get(m[k][i], "R4", 0);
  endtask

  task automatic wpw(input int k, input logic [63:0] guess, input logic [63:0] nid, input logic [63:0] npw);
    bit ok;
    cmd(8'h5A, 2'(k), 6'h00, "R7");
    send_id(k);
    ok = (guess == get64(k, 0));
    for (int i = 0; i < 8; i++) put(guess[8*i +: 8], "R7");
    if (ok) for (int i = 0; i < 64; i++) m[k][i] = 8'h00;
    for (int i = 0; i < 8; i++) begin
      put(nid[8*i +: 8], "R7");
      if (ok) m[k][i] = nid[8*i +: 8];
    end
    for (int i = 0; i < 8; i++) begin
      put(npw[8*i +: 8], "R7");
      if (ok) m[k][8+i] = npw[8*i +: 8];
    end
    put(8'hEE, "R7 extra byte discarded");
    breset();
  endtask

  task automatic wsk(input int k, input int a, input logic [63:0] pw, input int n, input logic [7:0] seed);
    bit ok;
    cmd(8'h99, 2'(k), 6'(a), "R5");
    send_id(k);
    ok = (pw == get64(k, 8));
    for (int i = 0; i < 8; i++) put(pw[8*i +: 8], "R5");
    for (int i = 0; i < n; i++) begin
      put(8'(seed ^ i), "R5");
      if (ok && a + i <= 63) m[k][a+i] = 8'(seed ^ i);
    end
    breset();
  endtask

  task automatic rsk(input int k, input int a, input logic [63:0] pw, input int n);
    bit ok;
    cmd(8'h66, 2'(k), 6'(a), "R6");
    send_id(k);
    ok = (pw == get64(k, 8));
    for (int i = 0; i < 8; i++) put(pw[8*i +: 8], "R6");
    for (int i = 0; i < n; i++)
      get((a + i > 63) ? 8'hFF : (ok ? m[k][a+i] : lf[7:0]), ok ? "R6 pass" : "R6 random", 0);
    breset();
  endtask

  task automatic cpy(input int k, input logic [63:0] sel, input logic [63:0] pw);
    int hit;
    bit ok;
    hit = -1;
    cmd(8'h3C, 2'(k), 6'h00, "R8");
    for (int i = 0; i < 9; i++) if (codes[i] == sel) hit = i;
    ok = (pw == get64(k, 8)) && (hit >= 0);
    for (int i = 0; i < 8; i++) put(sel[8*i +: 8], "R8");
    for (int i = 0; i < 8; i++) put(pw[8*i +: 8], "R8");
    if (ok)
      for (int b = 0; b < 8; b++)
        if (hit == 0 || hit == b + 1)
          for (int j = 0; j < 8; j++) begin
            m[k][b*8+j] = m[3][b*8+j];
            m[3][b*8+j] = 8'h00;
          end
    put(8'h00, "R8 trailing byte discarded");
    breset();
  endtask

  initial begin
    codes[0] = 64'h7F5A5D57517F5656; codes[1] = 64'h4C696E649DB39A9A;
    codes[2] = 64'h4C69919B624C9A9A; codes[3] = 64'h4C966E9B62B3659A;
    codes[4] = 64'h4366616B6D436A6A; codes[5] = 64'hBC999E9492BC9595;
    codes[6] = 64'hB36991649D4C9A65; codes[7] = 64'hB3966E649DB36565;
    codes[8] = 64'hB396919B624C6565;
    for (int a = 0; a < 4; a++) for (int i = 0; i < 64; i++) m[a][i] = 8'h00;
    lf = 16'hACE1;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(rx_ready === 1'b1 && tx_valid === 1'b0, "R10 reset state", {rx_ready, tx_valid}, 2'b10);

    rsp(0, 66, -1);                                  // R10 storage clear, R3 tail
    wsp(6'h3C, 6, 8'h21);                            // R2 stops after 3Fh
    rsp(6'h3A, 8, 2);                                // R3 and R10 stall
    wpw(1, 64'h0, 64'h1122334455667788, 64'hA5A50F0F5A5AF0F0);   // R7 match
    rsk(1, 0, 64'hA5A50F0F5A5AF0F0, 64);             // R7 result, R6 pass
    wpw(1, 64'h1, 64'h9999999999999999, 64'h1);      // R7 mismatch
    rsk(1, 0, 64'hA5A50F0F5A5AF0F0, 16);
    wsp(0, 64, 8'h05);
    cpy(1, codes[3], 64'hA5A50F0F5A5AF0F0);          // R8 single block
    rsp(0, 64, -1);
    rsk(1, 6'h10, 64'hA5A50F0F5A5AF0F0, 8);
    cpy(1, codes[5], 64'h1234);                      // R8 wrong password
    cpy(1, 64'h0123, 64'hA5A50F0F5A5AF0F0);          // R8 unknown selector
    rsp(0, 64, -1);
    cpy(2, codes[0], 64'h0);                         // R8 whole area
    rsp(0, 64, -1);
    rsk(2, 0, get64(2, 8), 64);
    wsk(1, 6'h20, 64'hA5A50F0F5A5AF0F0, 40, 8'h6C);  // R5 match, tail discarded
    rsk(1, 6'h20, 64'hA5A50F0F5A5AF0F0, 34);
    wsk(1, 6'h30, 64'hBAD, 4, 8'h11);                // R5 mismatch
    rsk(1, 6'h30, 64'hA5A50F0F5A5AF0F0, 16);
    rsk(0, 6'h3C, 64'h77, 6);                        // R6 random then FFh

    // R1: silent after a bad complement, an unknown code and a low write-subkey start
    put(8'h96, "R1"); put(8'hC5, "R1"); put(8'h00, "R1");
    for (int i = 0; i < 3; i++) put(8'h5F, "R1 silent");
    breset();
    cmd(8'h11, 2'b11, 6'h05, "R1");
    put(8'h5F, "R1 silent");
    breset();
    cmd(8'h99, 2'b00, 6'h05, "R1");
    put(8'h5F, "R1 silent");
    breset();
    rsp(0, 8, -1);

    // R9: bus reset in the middle of a scratchpad read
    cmd(8'h69, 2'b11, 6'h00, "R9");
    get(m[3][0], "R9", 0);
    breset();
    @(negedge clk);
    check(rx_ready === 1'b1 && tx_valid === 1'b0, "R9 after bus reset", {rx_ready, tx_valid}, 2'b10);
    wsp(6'h02, 2, 8'h40);
    rsp(0, 4, -1);

    ended = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #400000;
    if (!ended) begin
      fails++;
      $display("FAIL R10 watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule